// File: doc/BRIEF.md
# Predicate redirection lookup table

This block turns a register number into the element-enable mask that governs a vector-style operation. Each destination register, integer or floating-point, has its own entry in a mapping table. An entry is either off, or it names an integer register that holds the mask and says whether that mask is used as stored or bit-inverted. The mask value itself always comes from the integer register file, even when the operation is a floating-point one. The block reaches that file through a combinational read port.

Software loads up to sixteen packed configuration slots through a write port. Each slot carries a live bit, a table-select bit, a target register, a mask register and an invert flag. A commit pulse then rebuilds both tables. The rebuild first clears every entry of both tables, then walks the slots in ascending order, one slot per cycle. While the rebuild runs, lookups are held back. An accepted lookup delivers its mask through a result register one cycle later.

Top module: `pred_redirect_lut`

## Requirements
- R1: After reset, busy_o and lk_valid_o are 0, lk_ready_o is 1, and every lookup of either table returns an all-ones mask.
- R2: A lookup whose table entry is off returns all ones, whatever the register file holds.
- R3: A lookup whose entry is on and not inverted returns the value of the integer register named by that entry's mask index. The block drives that index on rf_addr_o.
- R4: A lookup whose entry is on with the invert flag set returns the bitwise complement of that integer register.
- R5: lk_fp_i = 0 selects the integer table and lk_fp_i = 1 selects the floating-point table. A configuration slot fills the integer table when cfg_fp_i = 0 and the floating-point table when cfg_fp_i = 1. Both tables take their mask from the integer register file.
- R6: A commit clears all entries of both tables before any slot is applied. A register targeted by no live slot of the current configuration reads as off, even if an earlier configuration turned it on.
- R7: Slots are applied in ascending slot order. When several live slots target the same register of the same table, the highest-numbered one decides its entry.
- R8: A slot written with cfg_live_i = 0 changes no table entry during a rebuild.
- R9: A commit accepted while idle raises busy_o for exactly NUM_CFG+1 cycles. Commits and configuration writes presented while busy_o is 1 are ignored.
- R10: lk_ready_o is 0 while busy_o is 1, and a pending request waits. A request accepted with lk_ready_o = 1 gives lk_valid_o = 1 with its mask in the following cycle. No result appears in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration slot write strobe |
| cfg_idx_i | input | $clog2(NUM_CFG) | Slot being written |
| cfg_live_i | input | 1 | Slot takes part in rebuilds |
| cfg_fp_i | input | 1 | Table select: 0 integer, 1 floating-point |
| cfg_tgt_i | input | $clog2(NUM_REGS) | Register whose entry the slot sets |
| cfg_pidx_i | input | $clog2(NUM_REGS) | Integer register holding the mask |
| cfg_inv_i | input | 1 | Use the complemented mask |
| cfg_commit_i | input | 1 | Start a table rebuild |
| busy_o | output | 1 | Rebuild in progress |
| lk_req_i | input | 1 | Lookup request, held until accepted |
| lk_fp_i | input | 1 | Lookup table select: 0 integer, 1 floating-point |
| lk_reg_i | input | $clog2(NUM_REGS) | Register being looked up |
| lk_ready_o | output | 1 | Lookup can be accepted this cycle |
| lk_valid_o | output | 1 | Result valid |
| lk_mask_o | output | MASK_W | Effective element mask |
| rf_addr_o | output | $clog2(NUM_REGS) | Integer register file read address |
| rf_data_i | input | MASK_W | Integer register file read data |

## Verification
The bench builds several arithmetic configurations that include duplicate targets, dead slots and both table selects. After each one it looks up all 64 entries. A design that swapped the tables, read the mask from the wrong register or ignored the invert flag would return a wrong mask for some register. A design that let an earlier duplicate slot win would keep a stale mask. A design that skipped the clear would keep entries alive from the previous configuration. Writes and commits issued during a rebuild would change an entry or stretch busy_o if the design failed to ignore them. A lookup issued just after a commit would return a pre-rebuild or partially built mask if it were not held for the full NUM_CFG+1 cycles.

// File: rtl/pred_lut_pkg.sv
package pred_lut_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_CLEAR = 2'd1,
        SEQ_WALK  = 2'd2
    } seq_state_e;

    // Value of the table-select bit for each table
    localparam int unsigned TBL_INT = 0;
    localparam int unsigned TBL_FP  = 1;

endpackage

// File: rtl/plut_cfg_regs.sv
module plut_cfg_regs #(
    parameter  int unsigned NUM_CFG = 16,
    parameter  int unsigned REG_W   = 5,
    localparam int unsigned CIDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [CIDX_W-1:0] wr_idx_i,
    input  logic              wr_live_i,
    input  logic              wr_fp_i,
    input  logic [REG_W-1:0]  wr_tgt_i,
    input  logic [REG_W-1:0]  wr_pidx_i,
    input  logic              wr_inv_i,
    input  logic [CIDX_W-1:0] rd_idx_i,
    output logic              rd_live_o,
    output logic              rd_fp_o,
    output logic [REG_W-1:0]  rd_tgt_o,
    output logic [REG_W-1:0]  rd_pidx_o,
    output logic              rd_inv_o
);

    typedef struct packed {
        logic [NUM_CFG-1:0]            live;
        logic [NUM_CFG-1:0]            fp;
        logic [NUM_CFG-1:0][REG_W-1:0] tgt;
        logic [NUM_CFG-1:0][REG_W-1:0] pidx;
        logic [NUM_CFG-1:0]            inv;
    } slots_t;

    slots_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.live[wr_idx_i] = wr_live_i;
            st_d.fp[wr_idx_i]   = wr_fp_i;
            st_d.tgt[wr_idx_i]  = wr_tgt_i;
            st_d.pidx[wr_idx_i] = wr_pidx_i;
            st_d.inv[wr_idx_i]  = wr_inv_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_live_o = st_q.live[rd_idx_i];
    assign rd_fp_o   = st_q.fp[rd_idx_i];
    assign rd_tgt_o  = st_q.tgt[rd_idx_i];
    assign rd_pidx_o = st_q.pidx[rd_idx_i];
    assign rd_inv_o  = st_q.inv[rd_idx_i];

endmodule

// File: rtl/plut_seq.sv
module plut_seq
    import pred_lut_pkg::*;
#(
    parameter  int unsigned NUM_CFG = 16,
    localparam int unsigned CIDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              commit_i,
    output logic              busy_o,
    output logic              clear_o,
    output logic              apply_o,
    output logic [CIDX_W-1:0] idx_o
);

    localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(NUM_CFG - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CIDX_W-1:0] idx;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.st)
            SEQ_IDLE: begin
                if (commit_i) begin
                    sq_d.st  = SEQ_CLEAR;
                    sq_d.idx = '0;
                end
            end
            SEQ_CLEAR: begin
                sq_d.st = SEQ_WALK;
            end
            SEQ_WALK: begin
                if (sq_q.idx == LAST_IDX) begin
                    sq_d.st  = SEQ_IDLE;
                    sq_d.idx = '0;
                end else begin
                    sq_d.idx = sq_q.idx + 1'b1;
                end
            end
            default: begin
                sq_d.st  = SEQ_IDLE;
                sq_d.idx = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sq_q <= '{st: SEQ_IDLE, idx: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o  = (sq_q.st != SEQ_IDLE);
    assign clear_o = (sq_q.st == SEQ_CLEAR);
    assign apply_o = (sq_q.st == SEQ_WALK);
    assign idx_o   = sq_q.idx;

endmodule

// File: rtl/plut_table.sv
module plut_table #(
    parameter  int unsigned NUM_REGS = 32,
    localparam int unsigned REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_reg_i,
    input  logic [REG_W-1:0] wr_pidx_i,
    input  logic             wr_inv_i,
    input  logic [REG_W-1:0] rd_reg_i,
    output logic             rd_en_o,
    output logic [REG_W-1:0] rd_pidx_o,
    output logic             rd_inv_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0]            en;
        logic [NUM_REGS-1:0][REG_W-1:0] pidx;
        logic [NUM_REGS-1:0]            inv;
    } tbl_t;

    tbl_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (clear_i) begin
            tb_d = '0;
        end else if (wr_en_i) begin
            tb_d.en[wr_reg_i]   = 1'b1;
            tb_d.pidx[wr_reg_i] = wr_pidx_i;
            tb_d.inv[wr_reg_i]  = wr_inv_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign rd_en_o   = tb_q.en[rd_reg_i];
    assign rd_pidx_o = tb_q.pidx[rd_reg_i];
    assign rd_inv_o  = tb_q.inv[rd_reg_i];

endmodule

// File: rtl/pred_redirect_lut.sv
module pred_redirect_lut
    import pred_lut_pkg::*;
#(
    parameter  int unsigned NUM_CFG  = 16,
    parameter  int unsigned NUM_REGS = 32,
    parameter  int unsigned MASK_W   = 64,
    localparam int unsigned REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned CIDX_W   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [CIDX_W-1:0] cfg_idx_i,
    input  logic              cfg_live_i,
    input  logic              cfg_fp_i,
    input  logic [REG_W-1:0]  cfg_tgt_i,
    input  logic [REG_W-1:0]  cfg_pidx_i,
    input  logic              cfg_inv_i,
    input  logic              cfg_commit_i,
    output logic              busy_o,
    input  logic              lk_req_i,
    input  logic              lk_fp_i,
    input  logic [REG_W-1:0]  lk_reg_i,
    output logic              lk_ready_o,
    output logic              lk_valid_o,
    output logic [MASK_W-1:0] lk_mask_o,
    output logic [REG_W-1:0]  rf_addr_o,
    input  logic [MASK_W-1:0] rf_data_i
);

    localparam int unsigned NUM_TBL = 2;

    // Rebuild sequencer
    logic              seq_busy;
    logic              seq_clear;
    logic              seq_apply;
    logic [CIDX_W-1:0] seq_idx;

    plut_seq #(.NUM_CFG(NUM_CFG)) i_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .commit_i (cfg_commit_i),
        .busy_o   (seq_busy),
        .clear_o  (seq_clear),
        .apply_o  (seq_apply),
        .idx_o    (seq_idx)
    );

    // Configuration slots, frozen while a rebuild walks them
    logic             slot_live;
    logic             slot_fp;
    logic [REG_W-1:0] slot_tgt;
    logic [REG_W-1:0] slot_pidx;
    logic             slot_inv;

    plut_cfg_regs #(.NUM_CFG(NUM_CFG), .REG_W(REG_W)) i_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (cfg_we_i && !seq_busy),
        .wr_idx_i  (cfg_idx_i),
        .wr_live_i (cfg_live_i),
        .wr_fp_i   (cfg_fp_i),
        .wr_tgt_i  (cfg_tgt_i),
        .wr_pidx_i (cfg_pidx_i),
        .wr_inv_i  (cfg_inv_i),
        .rd_idx_i  (seq_idx),
        .rd_live_o (slot_live),
        .rd_fp_o   (slot_fp),
        .rd_tgt_o  (slot_tgt),
        .rd_pidx_o (slot_pidx),
        .rd_inv_o  (slot_inv)
    );

    // One mapping table per register class
    logic [NUM_TBL-1:0]            tbl_en;
    logic [NUM_TBL-1:0][REG_W-1:0] tbl_pidx;
    logic [NUM_TBL-1:0]            tbl_inv;

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        logic slot_hit;
        assign slot_hit = seq_apply && slot_live && (slot_fp == (t == TBL_FP));

        plut_table #(.NUM_REGS(NUM_REGS)) i_tbl (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .clear_i   (seq_clear),
            .wr_en_i   (slot_hit),
            .wr_reg_i  (slot_tgt),
            .wr_pidx_i (slot_pidx),
            .wr_inv_i  (slot_inv),
            .rd_reg_i  (lk_reg_i),
            .rd_en_o   (tbl_en[t]),
            .rd_pidx_o (tbl_pidx[t]),
            .rd_inv_o  (tbl_inv[t])
        );
    end

    // Lookup result stage
    typedef struct packed {
        logic              valid;
        logic [MASK_W-1:0] mask;
    } res_t;

    res_t rs_d, rs_q;

    logic              sel_en;
    logic [REG_W-1:0]  sel_pidx;
    logic              sel_inv;
    logic [MASK_W-1:0] eff_mask;
    logic              accept;

    always_comb begin
        sel_en   = lk_fp_i ? tbl_en[TBL_FP]   : tbl_en[TBL_INT];
        sel_pidx = lk_fp_i ? tbl_pidx[TBL_FP] : tbl_pidx[TBL_INT];
        sel_inv  = lk_fp_i ? tbl_inv[TBL_FP]  : tbl_inv[TBL_INT];
        if (!sel_en) begin
            eff_mask = '1;
        end else if (sel_inv) begin
            eff_mask = ~rf_data_i;
        end else begin
            eff_mask = rf_data_i;
        end
        accept   = lk_req_i && !seq_busy;
        rs_d       = rs_q;
        rs_d.valid = accept;
        if (accept) begin
            rs_d.mask = eff_mask;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rf_addr_o  = sel_pidx;
    assign busy_o     = seq_busy;
    assign lk_ready_o = !seq_busy;
    assign lk_valid_o = rs_q.valid;
    assign lk_mask_o  = rs_q.mask;

endmodule

// File: rtl/plut_checker.sv
module plut_checker #(
    parameter int unsigned NUM_CFG = 16
) (
    input logic clk_i,
    input logic rst_ni,
    input logic cfg_commit_i,
    input logic busy_o,
    input logic lk_req_i,
    input logic lk_ready_o,
    input logic lk_valid_o
);

    localparam int unsigned RUN_LEN = NUM_CFG + 1;
    localparam int unsigned CNT_W   = $clog2(RUN_LEN + 2);

    logic [CNT_W-1:0] busy_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            busy_run_q <= '0;
        end else if (busy_o) begin
            busy_run_q <= busy_run_q + 1'b1;
        end else begin
            busy_run_q <= '0;
        end
    end

    // R9: an idle commit starts a rebuild
    a_r9_commit_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_commit_i && !busy_o) |=> busy_o);

    // R9: every rebuild lasts exactly NUM_CFG+1 cycles
    a_r9_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (busy_run_q == CNT_W'(RUN_LEN)));

    // R10: an accepted request yields a result next cycle
    a_r10_result_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_req_i && lk_ready_o) |=> lk_valid_o);

    // R10: no result without an accepted request
    a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_o |-> $past(lk_req_i && lk_ready_o));

    // R10: nothing is accepted in a busy cycle
    a_r10_stall_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> !lk_valid_o);

endmodule

bind pred_redirect_lut plut_checker #(.NUM_CFG(NUM_CFG)) i_plut_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_commit_i (cfg_commit_i),
    .busy_o       (busy_o),
    .lk_req_i     (lk_req_i),
    .lk_ready_o   (lk_ready_o),
    .lk_valid_o   (lk_valid_o)
);

// File: tb/test_pred_redirect_lut.sv
module test_pred_redirect_lut;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCFG = 16;
    localparam int NREG = 32;
    localparam int MW   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_idx = '0;
    logic          cfg_live = 1'b0, cfg_fp = 1'b0, cfg_inv = 1'b0, cfg_commit = 1'b0;
    logic [4:0]    cfg_tgt = '0, cfg_pidx = '0;
    logic          busy;
    logic          lk_req = 1'b0, lk_fp = 1'b0;
    logic [4:0]    lk_reg = '0;
    logic          lk_ready, lk_valid;
    logic [MW-1:0] lk_mask;
    logic [4:0]    rf_addr;
    logic [MW-1:0] rf_data;

    always #10 clk = ~clk;

    pred_redirect_lut i_pred_redirect_lut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_live_i(cfg_live), .cfg_fp_i(cfg_fp),
        .cfg_tgt_i(cfg_tgt), .cfg_pidx_i(cfg_pidx), .cfg_inv_i(cfg_inv),
        .cfg_commit_i(cfg_commit), .busy_o(busy),
        .lk_req_i(lk_req), .lk_fp_i(lk_fp), .lk_reg_i(lk_reg),
        .lk_ready_o(lk_ready), .lk_valid_o(lk_valid), .lk_mask_o(lk_mask),
        .rf_addr_o(rf_addr), .rf_data_i(rf_data)
    );

    function automatic logic [MW-1:0] rf_val(input logic [4:0] a);
        return 64'(64'h9E37_79B9_7F4A_7C15 * 64'(int'(a) + 1)) ^ 64'(a);
    endfunction

    always_comb rf_data = rf_val(rf_addr);

    // Shadow of the slots and model of both tables
    logic       c_live [NCFG];
    logic       c_fp   [NCFG];
    logic [4:0] c_tgt  [NCFG];
    logic [4:0] c_pidx [NCFG];
    logic       c_inv  [NCFG];
    logic       m_en   [2][NREG];
    logic [4:0] m_pidx [2][NREG];
    logic       m_inv  [2][NREG];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [MW-1:0] act,
                       input logic [MW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] exp_mask(input int t, input int r);
        if (!m_en[t][r]) return '1;
        return m_inv[t][r] ? ~rf_val(m_pidx[t][r]) : rf_val(m_pidx[t][r]);
    endfunction

    task automatic model_apply();
        for (int t = 0; t < 2; t++)
            for (int r = 0; r < NREG; r++) begin
                m_en[t][r] = 1'b0; m_pidx[t][r] = '0; m_inv[t][r] = 1'b0;
            end
        for (int i = 0; i < NCFG; i++)
            if (c_live[i]) begin
                m_en[int'(c_fp[i])][c_tgt[i]]   = 1'b1;
                m_pidx[int'(c_fp[i])][c_tgt[i]] = c_pidx[i];
                m_inv[int'(c_fp[i])][c_tgt[i]]  = c_inv[i];
            end
    endtask

    task automatic raw_write(input int i, input bit lv, input bit fp, input int tg,
                             input int pi, input bit iv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(i); cfg_live = lv; cfg_fp = fp;
        cfg_tgt = 5'(tg); cfg_pidx = 5'(pi); cfg_inv = iv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_slot(input int i, input bit lv, input bit fp, input int tg,
                              input int pi, input bit iv);
        raw_write(i, lv, fp, tg, pi, iv);
        c_live[i] = lv; c_fp[i] = fp; c_tgt[i] = 5'(tg); c_pidx[i] = 5'(pi); c_inv[i] = iv;
    endtask

    // Commit and count busy cycles; optionally disturb the rebuild
    task automatic commit_wait(input bit disturb);
        int cnt;
        @(negedge clk);
        cfg_commit = 1'b1;
        @(negedge clk);
        cfg_commit = 1'b0;
        model_apply();
        cnt = 0;
        while (busy) begin
            if (disturb && cnt == 3) begin
                cfg_we = 1'b1; cfg_idx = 4'd0; cfg_live = 1'b1; cfg_fp = ~c_fp[0];
                cfg_tgt = c_tgt[0] + 5'd1; cfg_pidx = c_pidx[0] + 5'd1; cfg_inv = ~c_inv[0];
                cfg_commit = 1'b1;
            end else begin
                cfg_we = 1'b0; cfg_commit = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        cfg_we = 1'b0; cfg_commit = 1'b0;
        chk(cnt == NCFG + 1, "R9 busy length", 64'(cnt), 64'(NCFG + 1));
    endtask

    task automatic lookup(input int t, input int r, input string req);
        @(negedge clk);
        lk_req = 1'b1; lk_fp = t[0]; lk_reg = 5'(r);
        while (!lk_ready) @(negedge clk);
        @(negedge clk);
        lk_req = 1'b0;
        chk(lk_valid === 1'b1, {req, " valid"}, 64'(lk_valid), 64'd1);
        chk(lk_mask === exp_mask(t, r), req, lk_mask, exp_mask(t, r));
    endtask

    task automatic sweep(input string req);
        for (int t = 0; t < 2; t++)
            for (int r = 0; r < NREG; r++)
                lookup(t, r, req);
    endtask

    task automatic load_pattern(input int p);
        for (int i = 0; i < NCFG; i++)
            write_slot(i, ((i + p) % 5) != 0, ((i * p + i) & 1) != 0, (i * 7 + p * 3) % NREG,
                       (i * 11 + p) % NREG, (((i >> 1) + p) & 1) != 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCFG; i++) begin
            c_live[i] = 0; c_fp[i] = 0; c_tgt[i] = '0; c_pidx[i] = '0; c_inv[i] = 0;
        end
        model_apply();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(lk_valid === 1'b0, "R1 valid", 64'(lk_valid), 64'd0);
        chk(lk_ready === 1'b1, "R1 ready", 64'(lk_ready), 64'd1);
        sweep("R1 reset mask");

        // R2 R3 R4 R5 R7 R8 on arithmetic patterns
        for (int p = 1; p <= 3; p++) begin
            load_pattern(p);
            commit_wait(1'b0);
            sweep("R3 R4 R5 pattern sweep");
        end

        // R7: duplicate targets, later slot wins; R8: dead slot has no effect
        for (int i = 0; i < NCFG; i++) write_slot(i, 0, 0, 0, 0, 0);
        write_slot(3, 1, 0, 7, 4, 0);
        write_slot(9, 1, 0, 7, 12, 1);
        write_slot(5, 1, 1, 7, 2, 0);
        write_slot(11, 0, 0, 20, 6, 0);
        write_slot(12, 1, 1, 0, 31, 1);
        commit_wait(1'b0);
        lookup(0, 7, "R7 later slot wins");
        chk(m_pidx[0][7] == 5'd12, "R7 model", 64'(m_pidx[0][7]), 64'd12);
        lookup(1, 7, "R5 fp table separate");
        lookup(0, 20, "R8 dead slot ignored");
        lookup(0, 0, "R2 disabled all ones");
        lookup(1, 0, "R4 fp inverted from int file");

        // R6: new configuration clears old entries
        for (int i = 0; i < NCFG; i++) write_slot(i, 0, 0, 0, 0, 0);
        write_slot(0, 1, 1, 19, 8, 0);
        commit_wait(1'b0);
        lookup(0, 7, "R6 old int entry cleared");
        lookup(1, 7, "R6 old fp entry cleared");
        sweep("R6 sweep after clear");

        // R9: writes and commits during busy ignored
        load_pattern(4);
        commit_wait(1'b1);
        commit_wait(1'b0);
        sweep("R9 busy write ignored");

        // R10: lookup held during rebuild
        begin
            int stalls;
            load_pattern(5);
            @(negedge clk);
            cfg_commit = 1'b1;
            @(negedge clk);
            cfg_commit = 1'b0;
            model_apply();
            lk_req = 1'b1; lk_fp = 1'b0; lk_reg = c_tgt[1];
            stalls = 0;
            while (!lk_ready) begin
                chk(lk_valid === 1'b0, "R10 no result while busy", 64'(lk_valid), 64'd0);
                stalls++;
                @(negedge clk);
            end
            chk(stalls == NCFG + 1, "R10 stall length", 64'(stalls), 64'(NCFG + 1));
            @(negedge clk);
            lk_req = 1'b0;
            chk(lk_valid === 1'b1, "R10 valid after stall", 64'(lk_valid), 64'd1);
            chk(lk_mask === exp_mask(0, int'(c_tgt[1])), "R10 post-rebuild mask",
                lk_mask, exp_mask(0, int'(c_tgt[1])));
            @(negedge clk);
            chk(lk_valid === 1'b0, "R10 single result", 64'(lk_valid), 64'd0);
        end
        sweep("R10 sweep");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule